// File: doc/BRIEF.md
# Clock Synthesizer Configuration Slave with Atomic Multiplier Commit

This block is a two-wire serial slave with 7-bit addressing. It holds the configuration registers of a programmable clock synthesizer. A master writes a register pointer and then one or more data bytes, and the pointer advances after each byte. To read, the master first sets the pointer with a write, then issues a repeated start with the read bit set and clocks out bytes until it sends a NACK.

The synthesizer's feedback multiplier has a 9-bit integer part and a 29-bit fractional part. These bits are spread over five byte registers. Four of them only load a staging copy. Writing the register that carries integer bits [8:3] moves the whole staged value to the active multiplier in one clock, so the synthesizer never sees a mix of old and new bytes. The block also holds:

- the loop-compensation factors,
- the two output dividers,
- the output-enable bit and the state the output takes while disabled,
- a calibrate bit that issues a one-cycle pulse,
- a self-clearing soft reset.

SCL and SDA arrive as plain inputs and are oversampled by the system clock. SDA is driven open-drain through an enable.

Top module: `cfg_i2c_slave`

## Requirements
- R1: After `rst_n` is released, the outputs take their parameter defaults. The output enable is 1, the disabled-state select is 00 and the calibrate pulse is low.
- R2: The slave acknowledges (pulls SDA low in the ninth clock) only the address byte that carries its own 7-bit address. For any other address it leaves SDA released for the rest of the transaction and changes no register.
- R3: A write is the address byte with bit 0 = 0, then a pointer byte, then data bytes. Each data byte is acknowledged and stored at the pointer. The pointer then advances by one and wraps from 255 to 0.
- R4: A read follows a pointer write and a repeated start, with address bit 0 = 1. Bytes go out MSB first from consecutive addresses. A master ACK asks for the next byte, and a master NACK ends the read.
- R5: The multiplier fields are laid out as follows:

  | Address | Bits | Multiplier field |
  |---|---|---|
  | 5 | 7:0 | fraction [7:0] |
  | 6 | 7:0 | fraction [15:8] |
  | 7 | 7:0 | fraction [23:16] |
  | 8 | 7:5 | integer [2:0] |
  | 8 | 4:0 | fraction [28:24] |
  | 9 | 5:0 | integer [8:3] |

  Addresses 5 to 9 read back the staged value.
- R6: Writes to addresses 5 to 8 leave the active multiplier unchanged. A write to address 9 loads the whole active multiplier in one clock, from the staged bytes and the new integer [8:3].
- R7: At address 132, bit 2 is the output enable (default 1). Writing bit 0 as 1 produces a calibrate pulse exactly one clock long. Bit 0 always reads as 0.
- R8: Writing address 128 with bit 7 set returns every register, including the active multiplier, to its default. Writing it with bit 7 clear has no effect. Address 128 always reads 0x00.
- R9: Address 14 bits 5:4 drive the disabled-state select output: 00 high impedance, 01 drive high, 10 drive low, 11 reserved. All four codes are stored.
- R10: An address with no register is acknowledged. A write to it is ignored, and a read of it returns 0x00.
- R11: Bits with no function inside an implemented register are not stored and read as 0:
  - address 9, bits 7:6
  - address 11, bits 7 and 3:2
  - address 14, bits 7:6 and 3:0
  - address 132, bits 7:3, 1 and 0
- R12: Address 0 holds the 8-bit loop factor. Address 10 holds divider A bits [7:0]. Address 11 holds divider B (3 bits) in bits 6:4 and divider A bits [9:8] in bits 1:0. All three appear on their outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_o | output | 1 | Data value driven when enabled (always 0, open-drain) |
| sda_oe | output | 1 | 1 pulls SDA low |
| mult_int_o | output | 9 | Active multiplier integer part |
| mult_frac_o | output | 29 | Active multiplier fractional part |
| loop_o | output | 8 | Loop-compensation factors |
| div_a_o | output | 10 | Divider A value |
| div_b_o | output | 3 | Divider B code |
| out_en_o | output | 1 | Output enable |
| off_state_o | output | 2 | Output state while disabled |
| cal_start_o | output | 1 | One-cycle calibrate request |

## Verification
The bench stages five multiplier bytes and checks that the active value still holds the old number until the fifth byte lands. A design that updated the active value byte by byte would show a torn multiplier there.

A burst write starting at address 255 must wrap to register 0. A design with a wider or saturating pointer would leave the loop factor untouched.

A foreign device address must neither be acknowledged nor alter state. A design that ignored address matching would corrupt the loop factor.

A full 256-byte read after a repeated start compares every address against a model. This exposes a design that stores reserved bits, answers unimplemented addresses with stale data, or lets the self-clearing bits read back as 1. A soft-reset write with bit 7 clear must change nothing. The real soft reset must also restore the active multiplier, not only the staged bytes.

// File: rtl/cfgi2c_pkg.sv
package cfgi2c_pkg;

    localparam int unsigned REG_AW = 8;

    localparam logic [REG_AW-1:0] A_LOOP   = 8'd0;
    localparam logic [REG_AW-1:0] A_FR0    = 8'd5;
    localparam logic [REG_AW-1:0] A_FR1    = 8'd6;
    localparam logic [REG_AW-1:0] A_FR2    = 8'd7;
    localparam logic [REG_AW-1:0] A_MIX    = 8'd8;
    localparam logic [REG_AW-1:0] A_COMMIT = 8'd9;
    localparam logic [REG_AW-1:0] A_DIVA   = 8'd10;
    localparam logic [REG_AW-1:0] A_DIVB   = 8'd11;
    localparam logic [REG_AW-1:0] A_OFFST  = 8'd14;
    localparam logic [REG_AW-1:0] A_SRST   = 8'd128;
    localparam logic [REG_AW-1:0] A_CTRL   = 8'd132;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_TXACK,
        ST_TXGAP,
        ST_SKIP
    } st_e;

    typedef enum logic [1:0] {
        RX_DEV,
        RX_PTR,
        RX_DATA
    } rxk_e;

    typedef struct packed {
        st_e               st;
        rxk_e              kind;
        logic [2:0]        cnt;
        logic [7:0]        sh;
        logic [REG_AW-1:0] ptr;
        logic              rw;
        logic              drive;
        logic              sda_oe;
        logic              wr_en;
        logic [REG_AW-1:0] wr_addr;
        logic [7:0]        wr_data;
    } fsm_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int W = STAGES + 1;

    logic [W-1:0] scl_d, scl_q;
    logic [W-1:0] sda_d, sda_q;
    logic         scl_s, scl_p, sda_p;

    always_comb begin
        scl_d = {scl_q[W-2:0], scl_i};
        sda_d = {sda_q[W-2:0], sda_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
        end else begin
            scl_q <= scl_d;
            sda_q <= sda_d;
        end
    end

    assign scl_s     = scl_q[STAGES-1];
    assign scl_p     = scl_q[STAGES];
    assign sda_s     = sda_q[STAGES-1];
    assign sda_p     = sda_q[STAGES];
    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/i2c_byte_fsm.sv
module i2c_byte_fsm
    import cfgi2c_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h55
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [7:0]        rd_data,
    output logic [REG_AW-1:0] rd_addr,
    output logic              wr_en,
    output logic [REG_AW-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              sda_oe
);
    fsm_t       d, q;
    logic [7:0] byte_in;
    logic [7:0] sh_next;

    always_comb begin
        d        = q;
        d.wr_en  = 1'b0;
        byte_in  = {q.sh[6:0], sda_s};
        sh_next  = {q.sh[6:0], 1'b0};
        if (stop_det) begin
            d.st     = ST_IDLE;
            d.sda_oe = 1'b0;
            d.drive  = 1'b0;
        end else if (start_det) begin
            d.st     = ST_RX;
            d.kind   = RX_DEV;
            d.cnt    = 3'd0;
            d.sda_oe = 1'b0;
            d.drive  = 1'b0;
        end else begin
            unique case (q.st)
                ST_RX: begin
                    if (scl_rise) begin
                        d.sh  = byte_in;
                        d.cnt = q.cnt + 3'd1;
                        if (q.cnt == 3'd7) begin
                            d.drive = 1'b0;
                            unique case (q.kind)
                                RX_DEV: begin
                                    if (byte_in[7:1] == DEV_ADDR) begin
                                        d.rw = byte_in[0];
                                        d.st = ST_ACK;
                                    end else begin
                                        d.st = ST_SKIP;
                                    end
                                end
                                RX_PTR: begin
                                    d.ptr = byte_in;
                                    d.st  = ST_ACK;
                                end
                                default: begin
                                    d.wr_en   = 1'b1;
                                    d.wr_addr = q.ptr;
                                    d.wr_data = byte_in;
                                    d.ptr     = q.ptr + 1'b1;
                                    d.st      = ST_ACK;
                                end
                            endcase
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        if (!q.drive) begin
                            d.drive  = 1'b1;
                            d.sda_oe = 1'b1;
                        end else begin
                            d.drive  = 1'b0;
                            d.sda_oe = 1'b0;
                            d.cnt    = 3'd0;
                            if (q.kind == RX_DEV && q.rw) begin
                                d.st     = ST_TX;
                                d.sh     = rd_data;
                                d.ptr    = q.ptr + 1'b1;
                                d.sda_oe = ~rd_data[7];
                            end else if (q.kind == RX_DEV) begin
                                d.st   = ST_RX;
                                d.kind = RX_PTR;
                            end else begin
                                d.st   = ST_RX;
                                d.kind = RX_DATA;
                            end
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (q.cnt == 3'd7) begin
                            d.st     = ST_TXACK;
                            d.sda_oe = 1'b0;
                        end else begin
                            d.sh     = sh_next;
                            d.cnt    = q.cnt + 3'd1;
                            d.sda_oe = ~sh_next[7];
                        end
                    end
                end
                ST_TXACK: begin
                    if (scl_rise) begin
                        d.st = sda_s ? ST_SKIP : ST_TXGAP;
                    end
                end
                ST_TXGAP: begin
                    if (scl_fall) begin
                        d.st     = ST_TX;
                        d.sh     = rd_data;
                        d.ptr    = q.ptr + 1'b1;
                        d.cnt    = 3'd0;
                        d.sda_oe = ~rd_data[7];
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.kind <= RX_DEV;
        end else begin
            q <= d;
        end
    end

    assign rd_addr = q.ptr;
    assign wr_en   = q.wr_en;
    assign wr_addr = q.wr_addr;
    assign wr_data = q.wr_data;
    assign sda_oe  = q.sda_oe;

    // R4: the slave moves SDA only after SCL has fallen, or when a bus condition resets it
    a_r4_sda_moves_on_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.sda_oe) |-> $past(scl_fall || start_det || stop_det));

    // R3: a register write is issued only on the SCL rise that completes a data byte
    a_r3_write_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        q.wr_en |-> $past(scl_rise));

endmodule

// File: rtl/cfg_regs.sv
module cfg_regs
    import cfgi2c_pkg::*;
#(
    parameter int          INT_W    = 9,
    parameter int          FRAC_W   = 29,
    parameter logic [8:0]  DEF_INT  = 9'd74,
    parameter logic [28:0] DEF_FRAC = 29'h097C65D3,
    parameter logic [7:0]  DEF_LOOP = 8'h34,
    parameter logic [9:0]  DEF_DIVA = 10'd16,
    parameter logic [2:0]  DEF_DIVB = 3'd0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [REG_AW-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic [INT_W-1:0]  mult_int,
    output logic [FRAC_W-1:0] mult_frac,
    output logic [7:0]        loop_f,
    output logic [9:0]        div_a,
    output logic [2:0]        div_b,
    output logic              out_en,
    output logic [1:0]        off_state,
    output logic              cal_pulse
);
    localparam int ILO_W = 3;
    localparam int IHI_W = INT_W - ILO_W;

    typedef struct packed {
        logic [7:0]        loop_f;
        logic [FRAC_W-1:0] fr;
        logic [ILO_W-1:0]  ilo;
        logic [IHI_W-1:0]  ihi;
        logic [INT_W-1:0]  aint;
        logic [FRAC_W-1:0] afr;
        logic [9:0]        diva;
        logic [2:0]        divb;
        logic [1:0]        offst;
        logic              oe;
        logic              cal;
    } rf_t;

    rf_t d, q;
    logic srst_hit, commit_hit;

    function automatic rf_t rf_default();
        rf_t v;
        v.loop_f = DEF_LOOP;
        v.fr     = DEF_FRAC;
        v.ilo    = DEF_INT[ILO_W-1:0];
        v.ihi    = DEF_INT[INT_W-1:ILO_W];
        v.aint   = DEF_INT;
        v.afr    = DEF_FRAC;
        v.diva   = DEF_DIVA;
        v.divb   = DEF_DIVB;
        v.offst  = 2'b00;
        v.oe     = 1'b1;
        v.cal    = 1'b0;
        return v;
    endfunction

    assign srst_hit   = wr_en && (wr_addr == A_SRST) && wr_data[7];
    assign commit_hit = wr_en && (wr_addr == A_COMMIT);

    always_comb begin
        d     = q;
        d.cal = 1'b0;
        if (srst_hit) begin
            d = rf_default();
        end else if (wr_en) begin
            unique case (wr_addr)
                A_LOOP:   d.loop_f     = wr_data;
                A_FR0:    d.fr[7:0]    = wr_data;
                A_FR1:    d.fr[15:8]   = wr_data;
                A_FR2:    d.fr[23:16]  = wr_data;
                A_MIX: begin
                    d.ilo         = wr_data[7:5];
                    d.fr[28:24]   = wr_data[4:0];
                end
                A_COMMIT: begin
                    d.ihi  = wr_data[IHI_W-1:0];
                    d.aint = {wr_data[IHI_W-1:0], q.ilo};
                    d.afr  = q.fr;
                end
                A_DIVA:   d.diva[7:0]  = wr_data;
                A_DIVB: begin
                    d.divb       = wr_data[6:4];
                    d.diva[9:8]  = wr_data[1:0];
                end
                A_OFFST:  d.offst      = wr_data[5:4];
                A_CTRL: begin
                    d.oe  = wr_data[2];
                    d.cal = wr_data[0];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= rf_default();
        else        q <= d;
    end

    always_comb begin
        unique case (rd_addr)
            A_LOOP:   rd_data = q.loop_f;
            A_FR0:    rd_data = q.fr[7:0];
            A_FR1:    rd_data = q.fr[15:8];
            A_FR2:    rd_data = q.fr[23:16];
            A_MIX:    rd_data = {q.ilo, q.fr[28:24]};
            A_COMMIT: rd_data = {2'b00, q.ihi};
            A_DIVA:   rd_data = q.diva[7:0];
            A_DIVB:   rd_data = {1'b0, q.divb, 2'b00, q.diva[9:8]};
            A_OFFST:  rd_data = {2'b00, q.offst, 4'b0000};
            A_CTRL:   rd_data = {5'b00000, q.oe, 2'b00};
            default:  rd_data = 8'h00;
        endcase
    end

    assign mult_int  = q.aint;
    assign mult_frac = q.afr;
    assign loop_f    = q.loop_f;
    assign div_a     = q.diva;
    assign div_b     = q.divb;
    assign out_en    = q.oe;
    assign off_state = q.offst;
    assign cal_pulse = q.cal;

    // R6: the active multiplier holds unless the commit register or soft reset is written
    a_r6_active_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit_hit && !srst_hit) |=> $stable({mult_int, mult_frac}));

    // R7: a calibrate pulse follows a control write with bit 0 set and lasts one cycle
    a_r7_cal_cause: assert property (@(posedge clk) disable iff (!rst_n)
        cal_pulse |-> $past(wr_en && wr_addr == A_CTRL && wr_data[0]));

    a_r7_cal_single: assert property (@(posedge clk) disable iff (!rst_n)
        cal_pulse |=> !cal_pulse);

    // R8: after a soft reset the output enable is back at its default of 1
    a_r8_srst_oe: assert property (@(posedge clk) disable iff (!rst_n)
        $past(srst_hit) |-> (out_en && off_state == 2'b00));

endmodule

// File: rtl/cfg_i2c_slave.sv
module cfg_i2c_slave
    import cfgi2c_pkg::*;
#(
    parameter logic [6:0]  DEV_ADDR    = 7'h55,
    parameter int          SYNC_STAGES = 2,
    parameter logic [8:0]  DEF_INT     = 9'd74,
    parameter logic [28:0] DEF_FRAC    = 29'h097C65D3,
    parameter logic [7:0]  DEF_LOOP    = 8'h34,
    parameter logic [9:0]  DEF_DIVA    = 10'd16,
    parameter logic [2:0]  DEF_DIVB    = 3'd0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        sda_o,
    output logic        sda_oe,
    output logic [8:0]  mult_int_o,
    output logic [28:0] mult_frac_o,
    output logic [7:0]  loop_o,
    output logic [9:0]  div_a_o,
    output logic [2:0]  div_b_o,
    output logic        out_en_o,
    output logic [1:0]  off_state_o,
    output logic        cal_start_o
);
    logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [7:0]        rd_data;
    logic [REG_AW-1:0] rd_addr;
    logic              wr_en;
    logic [REG_AW-1:0] wr_addr;
    logic [7:0]        wr_data;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_byte_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .sda_oe    (sda_oe)
    );

    cfg_regs #(
        .DEF_INT  (DEF_INT),
        .DEF_FRAC (DEF_FRAC),
        .DEF_LOOP (DEF_LOOP),
        .DEF_DIVA (DEF_DIVA),
        .DEF_DIVB (DEF_DIVB)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .mult_int  (mult_int_o),
        .mult_frac (mult_frac_o),
        .loop_f    (loop_o),
        .div_a     (div_a_o),
        .div_b     (div_b_o),
        .out_en    (out_en_o),
        .off_state (off_state_o),
        .cal_pulse (cal_start_o)
    );

    assign sda_o = 1'b0;

endmodule

// File: tb/sim_cfg_i2c_slave.sv
module sim_cfg_i2c_slave;

    localparam logic [6:0]  DEV   = 7'h55;
    localparam logic [8:0]  D_INT = 9'd74;
    localparam logic [28:0] D_FR  = 29'h097C65D3;
    localparam logic [7:0]  D_LP  = 8'h34;
    localparam logic [9:0]  D_DA  = 10'd16;
    localparam logic [2:0]  D_DB  = 3'd0;
    localparam int          Q     = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic sda_bus;
    logic sda_o, sda_oe;
    logic [8:0]  mult_int_o;
    logic [28:0] mult_frac_o;
    logic [7:0]  loop_o;
    logic [9:0]  div_a_o;
    logic [2:0]  div_b_o;
    logic        out_en_o;
    logic [1:0]  off_state_o;
    logic        cal_start_o;

    int n_chk = 0;
    int n_fail = 0;
    int cal_cnt = 0;
    int cal_exp = 0;
    logic done = 1'b0;

    logic [7:0] wbuf [0:15];
    logic [7:0] rbuf [0:255];

    // bench model of the register file
    logic [7:0]  m_lp;
    logic [28:0] m_fr, m_afr;
    logic [2:0]  m_ilo;
    logic [5:0]  m_ihi;
    logic [8:0]  m_aint;
    logic [9:0]  m_da;
    logic [2:0]  m_db;
    logic [1:0]  m_off;
    logic        m_oe;

    always #10 clk = ~clk;

    assign sda_bus = sda_m & ~(sda_oe & ~sda_o);

    cfg_i2c_slave #(
        .DEV_ADDR(DEV), .DEF_INT(D_INT), .DEF_FRAC(D_FR),
        .DEF_LOOP(D_LP), .DEF_DIVA(D_DA), .DEF_DIVB(D_DB)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
        .sda_o(sda_o), .sda_oe(sda_oe),
        .mult_int_o(mult_int_o), .mult_frac_o(mult_frac_o),
        .loop_o(loop_o), .div_a_o(div_a_o), .div_b_o(div_b_o),
        .out_en_o(out_en_o), .off_state_o(off_state_o),
        .cal_start_o(cal_start_o)
    );

    always @(posedge clk) if (cal_start_o) cal_cnt <= cal_cnt + 1;

    task automatic m_reset();
        m_lp = D_LP; m_fr = D_FR; m_afr = D_FR;
        m_ilo = D_INT[2:0]; m_ihi = D_INT[8:3]; m_aint = D_INT;
        m_da = D_DA; m_db = D_DB; m_off = 2'b00; m_oe = 1'b1;
    endtask

    task automatic m_write(input logic [7:0] a, input logic [7:0] v);
        case (a)
            8'd0:   m_lp = v;
            8'd5:   m_fr[7:0] = v;
            8'd6:   m_fr[15:8] = v;
            8'd7:   m_fr[23:16] = v;
            8'd8:   begin m_ilo = v[7:5]; m_fr[28:24] = v[4:0]; end
            8'd9:   begin m_ihi = v[5:0]; m_aint = {v[5:0], m_ilo}; m_afr = m_fr; end
            8'd10:  m_da[7:0] = v;
            8'd11:  begin m_db = v[6:4]; m_da[9:8] = v[1:0]; end
            8'd14:  m_off = v[5:4];
            8'd128: if (v[7]) m_reset();
            8'd132: begin m_oe = v[2]; if (v[0]) cal_exp = cal_exp + 1; end
            default: ;
        endcase
    endtask

    function automatic logic [7:0] m_read(input logic [7:0] a);
        case (a)
            8'd0:   return m_lp;
            8'd5:   return m_fr[7:0];
            8'd6:   return m_fr[15:8];
            8'd7:   return m_fr[23:16];
            8'd8:   return {m_ilo, m_fr[28:24]};
            8'd9:   return {2'b00, m_ihi};
            8'd10:  return m_da[7:0];
            8'd11:  return {1'b0, m_db, 2'b00, m_da[9:8]};
            8'd14:  return {2'b00, m_off, 4'h0};
            8'd132: return {5'b0, m_oe, 2'b00};
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic chk_outs(input string rq);
        chk({rq, " mult_int"}, 64'(mult_int_o), 64'(m_aint));
        chk({rq, " mult_frac"}, 64'(mult_frac_o), 64'(m_afr));
        chk({rq, " loop"}, 64'(loop_o), 64'(m_lp));
        chk({rq, " div_a"}, 64'(div_a_o), 64'(m_da));
        chk({rq, " div_b"}, 64'(div_b_o), 64'(m_db));
        chk({rq, " out_en"}, 64'(out_en_o), 64'(m_oe));
        chk({rq, " off_state"}, 64'(off_state_o), 64'(m_off));
        chk({rq, " cal count"}, 64'(cal_cnt), 64'(cal_exp));
    endtask

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; hold(Q);
        scl = 1'b1;   hold(Q);
        sda_m = 1'b0; hold(Q);
        scl = 1'b0;   hold(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; hold(Q);
        scl = 1'b1;   hold(Q);
        sda_m = 1'b1; hold(Q);
    endtask

    task automatic bus_bit(input logic b, output logic r);
        sda_m = b; hold(Q);
        scl = 1'b1; hold(Q);
        r = sda_bus; hold(Q);
        scl = 1'b0; hold(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic nack);
        logic r;
        for (int i = 7; i >= 0; i--) bus_bit(v[i], r);
        bus_bit(1'b1, nack);
    endtask

    task automatic recv_byte(input logic last, output logic [7:0] v);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            bus_bit(1'b1, r);
            v[i] = r;
        end
        bus_bit(last, r);
    endtask

    // write n bytes from wbuf starting at register a; returns OR of all NACK bits
    task automatic wr_regs(input logic [6:0] dv, input logic [7:0] a, input int n,
                           output logic any_nack);
        logic nk;
        bus_start();
        send_byte({dv, 1'b0}, nk); any_nack = nk;
        send_byte(a, nk); any_nack = any_nack | nk;
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], nk);
            any_nack = any_nack | nk;
        end
        bus_stop();
        if (dv == DEV) for (int i = 0; i < n; i++) m_write(8'(a + 8'(i)), wbuf[i]);
        hold(4);
    endtask

    task automatic rd_regs(input logic [7:0] a, input int n, output logic any_nack);
        logic nk;
        logic [7:0] v;
        bus_start();
        send_byte({DEV, 1'b0}, nk); any_nack = nk;
        send_byte(a, nk); any_nack = any_nack | nk;
        bus_start();
        send_byte({DEV, 1'b1}, nk); any_nack = any_nack | nk;
        for (int i = 0; i < n; i++) begin
            recv_byte(i == n - 1, v);
            rbuf[i] = v;
        end
        bus_stop();
        hold(4);
    endtask

    task automatic wr1(input logic [7:0] a, input logic [7:0] v, input string rq);
        logic nk;
        wbuf[0] = v;
        wr_regs(DEV, a, 1, nk);
        chk({rq, " ack"}, 64'(nk), 64'(0));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk = n_chk + 1;
            n_fail = n_fail + 1;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic nk;
        logic [8:0]  ti;
        logic [28:0] tf;
        m_reset();
        hold(5);
        rst_n = 1'b1;
        hold(5);

        // R1: reset defaults
        chk_outs("R1 reset");
        chk("R1 sda released", 64'(sda_oe), 64'(0));

        // R6 / R5: stage four bytes, active value must not move
        ti = 9'h12B; tf = 29'h1ABCDEF1;
        wbuf[0] = tf[7:0]; wbuf[1] = tf[15:8]; wbuf[2] = tf[23:16];
        wbuf[3] = {ti[2:0], tf[28:24]};
        wr_regs(DEV, 8'd5, 4, nk);
        chk("R3 burst ack", 64'(nk), 64'(0));
        chk_outs("R6 staged only");
        chk("R6 int unchanged", 64'(mult_int_o), 64'(D_INT));
        rd_regs(8'd5, 4, nk);
        chk("R4 read ack", 64'(nk), 64'(0));
        for (int i = 0; i < 4; i++) chk("R5 staged readback", 64'(rbuf[i]), 64'(wbuf[i]));
        wr1(8'd9, {2'b11, ti[8:3]}, "R6 commit");
        chk("R6 int committed", 64'(mult_int_o), 64'(ti));
        chk("R5 frac committed", 64'(mult_frac_o), 64'(tf));

        // R6: sweep of five-byte burst commits
        for (int k = 0; k < 8; k++) begin
            ti = 9'(k * 61 + 65);
            tf = 29'(k * 29'h0123457) ^ 29'h15555555;
            wbuf[0] = tf[7:0]; wbuf[1] = tf[15:8]; wbuf[2] = tf[23:16];
            wbuf[3] = {ti[2:0], tf[28:24]}; wbuf[4] = {2'b00, ti[8:3]};
            wr_regs(DEV, 8'd5, 5, nk);
            chk("R3 sweep ack", 64'(nk), 64'(0));
            chk("R6 sweep int", 64'(mult_int_o), 64'(ti));
            chk("R5 sweep frac", 64'(mult_frac_o), 64'(tf));
        end

        // R12 / R11 / R9: loop factor, dividers, off state with reserved bits set
        wr1(8'd0, 8'h5C, "R12 loop");
        wbuf[0] = 8'hA7; wbuf[1] = 8'hFF;
        wr_regs(DEV, 8'd10, 2, nk);
        chk("R12 div ack", 64'(nk), 64'(0));
        chk_outs("R12 dividers");
        chk("R12 div_a value", 64'(div_a_o), 64'(10'h3A7));
        for (int c = 0; c < 4; c++) begin
            wr1(8'd14, 8'(8'hCF | (c << 4)), "R9 off state");
            chk("R9 off_state code", 64'(off_state_o), 64'(c));
        end

        // R7: calibrate pulse and output enable
        wr1(8'd132, 8'h01, "R7 cal");
        chk_outs("R7 cal oe low");
        wr1(8'd132, 8'hFF, "R7 cal2");
        chk_outs("R7 cal oe high");
        rd_regs(8'd132, 1, nk);
        chk("R7 ctrl readback", 64'(rbuf[0]), 64'(8'h04));

        // R2: foreign device address
        wbuf[0] = 8'h00;
        wr_regs(7'h2A, 8'd0, 1, nk);
        chk("R2 foreign nack", 64'(nk), 64'(1));
        chk_outs("R2 foreign ignored");
        wr_regs(DEV ^ 7'h01, 8'd0, 1, nk);
        chk("R2 near address nack", 64'(nk), 64'(1));
        chk_outs("R2 near ignored");

        // R10: writes to unimplemented addresses are acked and ignored
        wr1(8'd1, 8'hA5, "R10 a1");
        wr1(8'd13, 8'hA5, "R10 a13");
        wr1(8'd127, 8'hA5, "R10 a127");
        wr1(8'd200, 8'hA5, "R10 a200");
        chk_outs("R10 no effect");

        // R8: soft reset register with bit 7 clear does nothing
        wr1(8'd128, 8'h7F, "R8 no reset");
        chk_outs("R8 bit7 clear");

        // R3: burst wraps from 255 to 0
        wbuf[0] = 8'h11; wbuf[1] = 8'hC3;
        wr_regs(DEV, 8'd255, 2, nk);
        chk("R3 wrap ack", 64'(nk), 64'(0));
        chk("R3 wrap loop", 64'(loop_o), 64'(8'hC3));

        // R4 / R10 / R11: full address-space burst read
        rd_regs(8'd0, 256, nk);
        chk("R4 full read ack", 64'(nk), 64'(0));
        for (int a = 0; a < 256; a++)
            chk($sformatf("R4 R10 R11 addr %0d", a), 64'(rbuf[a]), 64'(m_read(8'(a))));

        // R8: soft reset restores everything
        wr1(8'd128, 8'h80, "R8 reset");
        chk_outs("R8 soft reset");
        chk("R8 active int default", 64'(mult_int_o), 64'(D_INT));
        rd_regs(8'd5, 5, nk);
        for (int i = 0; i < 5; i++)
            chk("R8 staged default", 64'(rbuf[i]), 64'(m_read(8'(5 + i))));
        rd_regs(8'd128, 1, nk);
        chk("R8 reads zero", 64'(rbuf[0]), 64'(0));

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule